// File: doc/BRIEF.md
# Way-Hinting Branch Target Buffer

This block is a set-associative branch target buffer whose entries also carry two instruction-cache way hints: one for the cache line that holds the predicted target, and one for the line that follows in sequence. A fetch unit presents an address together with a flag from predecode. The flag says whether the instruction at that address is a branch. In the same cycle the block answers with a hit, the predicted target and both way hints. The next fetch can then enable a single instruction-cache way instead of all of them.

Instructions that are not branches can own entries too. Such an entry keeps only the sequential way hint, and it never reports a target. A partition setting splits the ways between the two access types: branch accesses get the lowest ways and the rest go to non-branch accesses. A shared setting lets both types use every way. Each lookup enables only the ways of its own type, and the enabled set is visible on an output vector. The write port inserts or refreshes one entry per cycle. It fills a free way of the right partition first. When the partition is full, it evicts the least recently used way of that partition.

Top module: `wayhint_btb`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses.
- R2: A lookup of an address that was written with the branch flag set returns lk_hit=1, lk_tgt_vld=1 and the stored target, target way hint and sequential way hint in the same cycle. On a miss all data outputs are zero.
- R3: part_sel=0 is shared mode and enables all ways for both access types. A value k>0 gives ways 0..k-1 to branch accesses and ways k..NUM_WAYS-1 to non-branch accesses. lk_way_en shows the enabled ways of the current lookup, and it is zero when lk_en is low.
- R4: A lookup hits only on a valid entry in an enabled way whose tag matches and whose stored access type equals lk_br.
- R5: On a hit by a non-branch lookup, lk_tgt_vld=0, lk_tgt=0 and lk_twp=0, and lk_fwp returns the stored sequential hint.
- R6: A write whose tag and access type already exist in its partition and set overwrites that entry in place. No second way is taken.
- R7: A write that creates a new entry uses the lowest-numbered invalid way of its partition, if there is one.
- R8: A write that creates a new entry into a full partition evicts the least recently used way of that partition. Ways outside the partition are left as they were.
- R9: A lookup hit and every write mark the used way as most recent. A lookup hit does not change recency if a write goes to the same set in the same cycle.
- R10: A lookup and a write in the same cycle see the contents from before the write. The write becomes visible to lookups from the next cycle on.
- R11: lk_hit_way is one-hot with the hitting way, and it is zero on a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| part_sel | input | 2 | Number of ways given to branch accesses; 0 selects shared mode |
| lk_en | input | 1 | Lookup request |
| lk_br | input | 1 | Lookup is by a branch (1) or a non-branch (0) |
| lk_addr | input | 32 | Fetch address looked up |
| lk_hit | output | 1 | Lookup hit |
| lk_tgt_vld | output | 1 | A taken-branch target is reported |
| lk_tgt | output | 32 | Predicted target address |
| lk_twp | output | 2 | Way hint for the target line |
| lk_fwp | output | 2 | Way hint for the sequential line |
| lk_way_en | output | 4 | Ways enabled by this lookup |
| lk_hit_way | output | 4 | One-hot way that hit |
| wr_en | input | 1 | Write request |
| wr_br | input | 1 | Written entry belongs to a branch |
| wr_addr | input | 32 | Instruction address of the entry |
| wr_tgt | input | 32 | Target to store (branches only) |
| wr_twp | input | 2 | Target way hint to store (branches only) |
| wr_fwp | input | 2 | Sequential way hint to store |

## Verification
The lookup port and the write port can act on the same set in the same clock cycle. That overlap decides both what the lookup returns (the old contents) and whether the lookup hit counts toward recency (it does not). Directed steps cause it on purpose: a lookup hit runs alongside a write that allocates into the same set, and a lookup runs while the same address is being written for the first time. Long stretches of random traffic confined to four sets and six tags then make the overlap frequent. A behavioural model in the bench holds per-way timestamps and decides hit, fill and eviction on every clock. A wrongly credited touch therefore shows up later as a different victim, and the next lookups in that set reveal it.

// File: rtl/wayhint_btb_pkg.sv
package wayhint_btb_pkg;

  // Ownership rule: mode 0 shares every way; mode k gives the low k ways to
  // branch accesses and the remainder to non-branch accesses.
  function automatic logic in_part(input int way, input int mode, input logic is_br);
    if (mode == 0) return 1'b1;
    if (is_br) return (way < mode);
    return (way >= mode);
  endfunction

endpackage

// File: rtl/wayhint_btb_way.sv
module wayhint_btb_way #(
  parameter int NUM_SETS = 512,
  parameter int ADDR_W   = 32,
  parameter int ICW      = 2,
  parameter int SET_W    = 9,
  parameter int TAG_W    = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [SET_W-1:0]  rd_set,
  input  logic [TAG_W-1:0]  rd_tag,
  input  logic              rd_br,
  output logic              rd_hit,
  output logic [ADDR_W-1:0] rd_tgt,
  output logic [ICW-1:0]    rd_twp,
  output logic [ICW-1:0]    rd_fwp,
  input  logic [SET_W-1:0]  wr_set,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic              wr_br,
  output logic              wr_match,
  output logic              wr_valid,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_tgt,
  input  logic [ICW-1:0]    wr_twp,
  input  logic [ICW-1:0]    wr_fwp
);

  logic              vld_q [NUM_SETS];
  logic              br_q  [NUM_SETS];
  logic [TAG_W-1:0]  tag_q [NUM_SETS];
  logic [ADDR_W-1:0] tgt_q [NUM_SETS];
  logic [ICW-1:0]    twp_q [NUM_SETS];
  logic [ICW-1:0]    fwp_q [NUM_SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SETS; s++) vld_q[s] <= 1'b0;
    end else if (wr_en) begin
      vld_q[wr_set] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      br_q[wr_set]  <= wr_br;
      tag_q[wr_set] <= wr_tag;
      tgt_q[wr_set] <= wr_tgt;
      twp_q[wr_set] <= wr_twp;
      fwp_q[wr_set] <= wr_fwp;
    end
  end

  // Read side: a disabled way reports nothing.
  assign rd_hit = rd_en && vld_q[rd_set] && (br_q[rd_set] == rd_br) && (tag_q[rd_set] == rd_tag);
  assign rd_tgt = rd_hit ? tgt_q[rd_set] : '0;
  assign rd_twp = rd_hit ? twp_q[rd_set] : '0;
  assign rd_fwp = rd_hit ? fwp_q[rd_set] : '0;

  // Probe side for the write port.
  assign wr_valid = vld_q[wr_set];
  assign wr_match = vld_q[wr_set] && (br_q[wr_set] == wr_br) && (tag_q[wr_set] == wr_tag);

endmodule

// File: rtl/wayhint_btb_lru.sv
module wayhint_btb_lru #(
  parameter int NUM_SETS = 512,
  parameter int NUM_WAYS = 4,
  parameter int SET_W    = 9,
  parameter int AGE_W    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                a_touch,
  input  logic [SET_W-1:0]    a_set,
  input  logic [NUM_WAYS-1:0] a_oh,
  input  logic [NUM_WAYS-1:0] a_mask,
  input  logic                b_touch,
  input  logic [SET_W-1:0]    b_set,
  input  logic [NUM_WAYS-1:0] b_oh,
  input  logic [NUM_WAYS-1:0] b_mask,
  input  logic [SET_W-1:0]    v_set,
  input  logic [NUM_WAYS-1:0] v_mask,
  output logic [NUM_WAYS-1:0] v_oh
);

  typedef logic [NUM_WAYS-1:0][AGE_W-1:0] ages_t;

  ages_t age_q [NUM_SETS];

  // Make the touched way youngest; age only the younger ways of the same partition.
  function automatic ages_t touch(input ages_t a, input logic [NUM_WAYS-1:0] m,
                                  input logic [NUM_WAYS-1:0] oh);
    ages_t r = a;
    logic [AGE_W-1:0] pivot = '0;
    for (int w = 0; w < NUM_WAYS; w++) if (oh[w]) pivot = a[w];
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (oh[w])                       r[w] = '0;
      else if (m[w] && (a[w] < pivot)) r[w] = a[w] + 1'b1;
    end
    return r;
  endfunction

  // Oldest way of the partition, lowest index on a tie.
  function automatic logic [NUM_WAYS-1:0] oldest(input ages_t a, input logic [NUM_WAYS-1:0] m);
    logic [NUM_WAYS-1:0] pick = '0;
    logic [AGE_W-1:0]    best = '0;
    logic                seen = 1'b0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (m[w] && (!seen || (a[w] > best))) begin
        pick    = '0;
        pick[w] = 1'b1;
        best    = a[w];
        seen    = 1'b1;
      end
    end
    return pick;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SETS; s++)
        for (int w = 0; w < NUM_WAYS; w++)
          age_q[s][w] <= AGE_W'(w);
    end else begin
      if (a_touch) age_q[a_set] <= touch(age_q[a_set], a_mask, a_oh);
      if (b_touch) age_q[b_set] <= touch(age_q[b_set], b_mask, b_oh);
    end
  end

  assign v_oh = oldest(age_q[v_set], v_mask);

endmodule

// File: rtl/wayhint_btb.sv
module wayhint_btb #(
  parameter int ADDR_W   = 32,
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 512,
  parameter int ICW      = 2,
  parameter int OFF_W    = 2,
  localparam int SET_W   = $clog2(NUM_SETS),
  localparam int TAG_W   = ADDR_W - SET_W - OFF_W,
  localparam int PM_W    = $clog2(NUM_WAYS),
  localparam int AGE_W   = $clog2(NUM_WAYS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PM_W-1:0]     part_sel,
  input  logic                lk_en,
  input  logic                lk_br,
  input  logic [ADDR_W-1:0]   lk_addr,
  output logic                lk_hit,
  output logic                lk_tgt_vld,
  output logic [ADDR_W-1:0]   lk_tgt,
  output logic [ICW-1:0]      lk_twp,
  output logic [ICW-1:0]      lk_fwp,
  output logic [NUM_WAYS-1:0] lk_way_en,
  output logic [NUM_WAYS-1:0] lk_hit_way,
  input  logic                wr_en,
  input  logic                wr_br,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [ADDR_W-1:0]   wr_tgt,
  input  logic [ICW-1:0]      wr_twp,
  input  logic [ICW-1:0]      wr_fwp
);

  function automatic logic [NUM_WAYS-1:0] lowest(input logic [NUM_WAYS-1:0] v);
    return v & (~v + {{(NUM_WAYS-1){1'b0}}, 1'b1});
  endfunction

  logic [SET_W-1:0] lk_set, wr_set;
  logic [TAG_W-1:0] lk_tag, wr_tag;
  assign lk_set = lk_addr[OFF_W +: SET_W];
  assign lk_tag = lk_addr[ADDR_W-1 -: TAG_W];
  assign wr_set = wr_addr[OFF_W +: SET_W];
  assign wr_tag = wr_addr[ADDR_W-1 -: TAG_W];
  wire unused_offsets = ^{lk_addr[OFF_W-1:0], wr_addr[OFF_W-1:0]};

  logic [NUM_WAYS-1:0] lk_mask, wr_mask;
  always_comb begin
    for (int w = 0; w < NUM_WAYS; w++) begin
      lk_mask[w] = wayhint_btb_pkg::in_part(w, int'(part_sel), lk_br);
      wr_mask[w] = wayhint_btb_pkg::in_part(w, int'(part_sel), wr_br);
    end
  end
  assign lk_way_en = lk_en ? lk_mask : '0;

  // Data written for a non-branch entry carries no target information.
  logic [ADDR_W-1:0] st_tgt;
  logic [ICW-1:0]    st_twp;
  assign st_tgt = wr_br ? wr_tgt : '0;
  assign st_twp = wr_br ? wr_twp : '0;

  logic [NUM_WAYS-1:0] rd_hit_v, pr_match_v, pr_valid_v, wr_way_oh;
  logic [ADDR_W-1:0]   rd_tgt_v [NUM_WAYS];
  logic [ICW-1:0]      rd_twp_v [NUM_WAYS];
  logic [ICW-1:0]      rd_fwp_v [NUM_WAYS];

  for (genvar g = 0; g < NUM_WAYS; g++) begin : g_way
    wayhint_btb_way #(
      .NUM_SETS(NUM_SETS), .ADDR_W(ADDR_W), .ICW(ICW), .SET_W(SET_W), .TAG_W(TAG_W)
    ) way_i (
      .clk(clk), .rst_n(rst_n),
      .rd_en(lk_way_en[g]), .rd_set(lk_set), .rd_tag(lk_tag), .rd_br(lk_br),
      .rd_hit(rd_hit_v[g]), .rd_tgt(rd_tgt_v[g]), .rd_twp(rd_twp_v[g]), .rd_fwp(rd_fwp_v[g]),
      .wr_set(wr_set), .wr_tag(wr_tag), .wr_br(wr_br),
      .wr_match(pr_match_v[g]), .wr_valid(pr_valid_v[g]),
      .wr_en(wr_way_oh[g]), .wr_tgt(st_tgt), .wr_twp(st_twp), .wr_fwp(wr_fwp)
    );
  end

  always_comb begin
    lk_tgt = '0;
    lk_twp = '0;
    lk_fwp = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      lk_tgt = lk_tgt | rd_tgt_v[w];
      lk_twp = lk_twp | rd_twp_v[w];
      lk_fwp = lk_fwp | rd_fwp_v[w];
    end
  end
  assign lk_hit_way = rd_hit_v;
  assign lk_hit     = |rd_hit_v;
  assign lk_tgt_vld = lk_hit && lk_br;

  // Write-side way choice: existing entry, else first free way, else oldest.
  logic [NUM_WAYS-1:0] upd_v, inv_v, vic_oh;
  logic wr_upd, wr_fill, wr_evict, lk_touch;
  assign upd_v    = pr_match_v & wr_mask;
  assign inv_v    = ~pr_valid_v & wr_mask;
  assign wr_upd   = wr_en && (|upd_v);
  assign wr_fill  = wr_en && !(|upd_v) && (|inv_v);
  assign wr_evict = wr_en && !(|upd_v) && !(|inv_v);

  always_comb begin
    if (wr_upd)       wr_way_oh = lowest(upd_v);
    else if (wr_fill) wr_way_oh = lowest(inv_v);
    else if (wr_en)   wr_way_oh = vic_oh;
    else              wr_way_oh = '0;
  end

  assign lk_touch = lk_hit && !(wr_en && (wr_set == lk_set));

  wayhint_btb_lru #(
    .NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS), .SET_W(SET_W), .AGE_W(AGE_W)
  ) lru_i (
    .clk(clk), .rst_n(rst_n),
    .a_touch(wr_en), .a_set(wr_set), .a_oh(wr_way_oh), .a_mask(wr_mask),
    .b_touch(lk_touch), .b_set(lk_set), .b_oh(rd_hit_v), .b_mask(lk_mask),
    .v_set(wr_set), .v_mask(wr_mask), .v_oh(vic_oh)
  );

endmodule

// File: rtl/wayhint_btb_chk.sv
module wayhint_btb_chk #(
  parameter int NUM_WAYS = 4,
  parameter int ADDR_W   = 32,
  parameter int ICW      = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                lk_en,
  input logic                lk_br,
  input logic                lk_hit,
  input logic                lk_tgt_vld,
  input logic [ADDR_W-1:0]   lk_tgt,
  input logic [ICW-1:0]      lk_twp,
  input logic [NUM_WAYS-1:0] lk_way_en,
  input logic [NUM_WAYS-1:0] lk_hit_way,
  input logic                wr_en,
  input logic [NUM_WAYS-1:0] wr_way_oh,
  input logic [NUM_WAYS-1:0] wr_mask,
  input logic [NUM_WAYS-1:0] upd_v,
  input logic [NUM_WAYS-1:0] inv_v
);

  AST_RESET_EMPTY: assert property (@(posedge clk) $rose(rst_n) |-> !lk_hit); // R1

  AST_IDLE_NO_WAYS: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_en |-> (lk_way_en == '0)); // R3

  AST_HIT_IN_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> ((lk_hit_way & ~lk_way_en) == '0)); // R4

  AST_NB_NO_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && !lk_br) |-> (!lk_tgt_vld && (lk_tgt == '0) && (lk_twp == '0))); // R5

  AST_UPDATE_IN_PLACE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (upd_v != '0)) |-> ($onehot(wr_way_oh) && ((wr_way_oh & upd_v) != '0))); // R6

  AST_FREE_WAY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (upd_v == '0) && (inv_v != '0)) |-> ((wr_way_oh & inv_v) != '0)); // R7

  AST_WRITE_IN_PART: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ($onehot(wr_way_oh) && ((wr_way_oh & ~wr_mask) == '0))); // R8

  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_hit_way)); // R11

endmodule

bind wayhint_btb wayhint_btb_chk #(
  .NUM_WAYS(NUM_WAYS), .ADDR_W(ADDR_W), .ICW(ICW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .lk_en(lk_en), .lk_br(lk_br), .lk_hit(lk_hit),
  .lk_tgt_vld(lk_tgt_vld), .lk_tgt(lk_tgt), .lk_twp(lk_twp), .lk_way_en(lk_way_en),
  .lk_hit_way(lk_hit_way), .wr_en(wr_en), .wr_way_oh(wr_way_oh), .wr_mask(wr_mask),
  .upd_v(upd_v), .inv_v(inv_v)
);

// File: tb/wayhint_btb_tb.sv
module wayhint_btb_tb_top;

  localparam int NW = 4;
  localparam int NS = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  part_sel = '0;
  logic        lk_en = 1'b0, lk_br = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        lk_hit, lk_tgt_vld;
  logic [31:0] lk_tgt;
  logic [1:0]  lk_twp, lk_fwp;
  logic [3:0]  lk_way_en, lk_hit_way;
  logic        wr_en = 1'b0, wr_br = 1'b0;
  logic [31:0] wr_addr = '0, wr_tgt = '0;
  logic [1:0]  wr_twp = '0, wr_fwp = '0;

  always #4 clk = ~clk;

  wayhint_btb dut_i (
    .clk(clk), .rst_n(rst_n), .part_sel(part_sel),
    .lk_en(lk_en), .lk_br(lk_br), .lk_addr(lk_addr),
    .lk_hit(lk_hit), .lk_tgt_vld(lk_tgt_vld), .lk_tgt(lk_tgt), .lk_twp(lk_twp),
    .lk_fwp(lk_fwp), .lk_way_en(lk_way_en), .lk_hit_way(lk_hit_way),
    .wr_en(wr_en), .wr_br(wr_br), .wr_addr(wr_addr), .wr_tgt(wr_tgt),
    .wr_twp(wr_twp), .wr_fwp(wr_fwp)
  );

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // Behavioural model: per-way contents and last-use timestamps.
  bit          m_vld [NS][NW];
  bit          m_br  [NS][NW];
  logic [20:0] m_tag [NS][NW];
  logic [31:0] m_tgt [NS][NW];
  logic [1:0]  m_twp [NS][NW];
  logic [1:0]  m_fwp [NS][NW];
  longint      m_use [NS][NW];
  longint      now = 0;

  function automatic bit owns(int mode, bit br, int w);
    if (mode == 0) return 1'b1;
    return br ? (w < mode) : (w >= mode);
  endfunction

  function automatic logic [31:0] mk(int tag, int set);
    return {21'(tag), 9'(set), 2'b00};
  endfunction

  task automatic model_clear();
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) begin
        m_vld[s][w] = 1'b0;
        m_use[s][w] = -(w + 1);
      end
  endtask

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", what, act, exp);
    end
  endtask

  // Compare outputs against the model, then advance one clock and update the model.
  task automatic cyc(string req);
    int ls, ws, hw, pick;
    bit eh;
    logic [3:0] emask;
    longint best;
    #1;
    ls = int'(lk_addr[10:2]);
    ws = int'(wr_addr[10:2]);
    eh = 1'b0; hw = -1; emask = '0;
    for (int w = 0; w < NW; w++) begin
      if (lk_en && owns(int'(part_sel), lk_br, w)) begin
        emask[w] = 1'b1;
        if (m_vld[ls][w] && m_br[ls][w] == lk_br && m_tag[ls][w] == lk_addr[31:11]) begin
          eh = 1'b1; hw = w;
        end
      end
    end
    chk({req, " R3 way enables"}, 32'(lk_way_en), 32'(emask));
    chk({req, " R4 hit"}, 32'(lk_hit), 32'(eh));
    chk({req, " R11 hit way"}, 32'(lk_hit_way), eh ? (32'd1 << hw) : 32'd0);
    chk({req, " R5 target valid"}, 32'(lk_tgt_vld), 32'(eh && lk_br));
    chk({req, " R2 target"}, lk_tgt, (eh && lk_br) ? m_tgt[ls][hw] : 32'd0);
    chk({req, " R2 target hint"}, 32'(lk_twp), (eh && lk_br) ? 32'(m_twp[ls][hw]) : 32'd0);
    chk({req, " R2 seq hint"}, 32'(lk_fwp), eh ? 32'(m_fwp[ls][hw]) : 32'd0);
    @(posedge clk);
    now++;
    if (eh && !(wr_en && ws == ls)) m_use[ls][hw] = now;
    if (wr_en) begin
      pick = -1;
      for (int w = 0; w < NW; w++)
        if (pick < 0 && owns(int'(part_sel), wr_br, w) && m_vld[ws][w] &&
            m_br[ws][w] == wr_br && m_tag[ws][w] == wr_addr[31:11]) pick = w;
      for (int w = 0; w < NW; w++)
        if (pick < 0 && owns(int'(part_sel), wr_br, w) && !m_vld[ws][w]) pick = w;
      if (pick < 0) begin
        best = 0;
        for (int w = 0; w < NW; w++)
          if (owns(int'(part_sel), wr_br, w) && (pick < 0 || m_use[ws][w] < best)) begin
            pick = w; best = m_use[ws][w];
          end
      end
      m_vld[ws][pick] = 1'b1;
      m_br[ws][pick]  = wr_br;
      m_tag[ws][pick] = wr_addr[31:11];
      m_tgt[ws][pick] = wr_br ? wr_tgt : 32'd0;
      m_twp[ws][pick] = wr_br ? wr_twp : 2'd0;
      m_fwp[ws][pick] = wr_fwp;
      m_use[ws][pick] = now;
    end
    @(negedge clk);
  endtask

  task automatic drive(bit le, bit lb, logic [31:0] la, bit we, bit wb, logic [31:0] wa,
                       logic [31:0] t, logic [1:0] tw, logic [1:0] fw);
    lk_en = le; lk_br = lb; lk_addr = la;
    wr_en = we; wr_br = wb; wr_addr = wa; wr_tgt = t; wr_twp = tw; wr_fwp = fw;
  endtask

  task automatic lk(bit br, logic [31:0] a, string req);
    drive(1'b1, br, a, 1'b0, 1'b0, '0, '0, '0, '0);
    cyc(req);
  endtask

  task automatic wr(bit br, logic [31:0] a, logic [31:0] t, logic [1:0] tw, logic [1:0] fw, string req);
    drive(1'b0, 1'b0, '0, 1'b1, br, a, t, tw, fw);
    cyc(req);
  endtask

  task automatic do_reset(logic [1:0] mode);
    @(negedge clk);
    rst_n = 1'b0;
    drive(1'b0, 1'b0, '0, 1'b0, 1'b0, '0, '0, '0, '0);
    part_sel = mode;
    repeat (3) @(posedge clk);
    model_clear();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic random_run(logic [1:0] mode, int n);
    do_reset(mode);
    for (int i = 0; i < n; i++) begin
      drive(1'($urandom), 1'($urandom), mk(int'($urandom % 6), int'($urandom % 4)),
            1'($urandom), 1'($urandom), mk(int'($urandom % 6), int'($urandom % 4)),
            $urandom, 2'($urandom), 2'($urandom));
      cyc("R9/R10 random");
    end
  endtask

  initial begin
    model_clear();
    // Reset state
    do_reset(2'd0);
    lk(1'b1, mk(1, 5), "R1 after reset");
    lk(1'b0, mk(0, 0), "R1 after reset");
    chk("R1 hit after reset", 32'(lk_hit), 32'd0);

    // Shared mode: basic store and lookup, non-branch entries, update in place
    wr(1'b1, mk(1, 5), 32'h0000_1000, 2'd1, 2'd2, "R2 write");
    lk(1'b1, mk(1, 5), "R2 lookup");
    lk(1'b0, mk(1, 5), "R4 type mismatch");
    wr(1'b0, mk(2, 5), 32'hDEAD_BEEF, 2'd3, 2'd3, "R5 write");
    lk(1'b0, mk(2, 5), "R5 lookup");
    wr(1'b1, mk(1, 5), 32'h0000_2000, 2'd3, 2'd0, "R6 rewrite");
    lk(1'b1, mk(1, 5), "R6 lookup");
    wr(1'b1, mk(3, 5), 32'h0000_3000, 2'd2, 2'd1, "R7 fill");
    wr(1'b1, mk(4, 5), 32'h0000_4000, 2'd0, 2'd3, "R7 fill");
    lk(1'b1, mk(4, 5), "R7 placement");
    wr(1'b1, mk(5, 5), 32'h0000_5000, 2'd1, 2'd1, "R8 evict");
    lk(1'b0, mk(2, 5), "R8 victim gone");
    lk(1'b1, mk(3, 5), "R9 refresh");
    wr(1'b1, mk(6, 5), 32'h0000_6000, 2'd2, 2'd2, "R9 evict after refresh");
    lk(1'b1, mk(3, 5), "R9 refreshed kept");
    lk(1'b1, mk(1, 5), "R9 older evicted");
    // Lookup hit and write to the same set in one cycle
    drive(1'b1, 1'b1, mk(3, 5), 1'b1, 1'b1, mk(7, 5), 32'h0000_7000, 2'd3, 2'd1);
    cyc("R9 same-set overlap");
    wr(1'b1, mk(8, 5), 32'h0000_8000, 2'd0, 2'd0, "R9 no credit from overlap");
    lk(1'b1, mk(3, 5), "R9 overlap victim");
    drive(1'b1, 1'b1, mk(8, 6), 1'b1, 1'b1, mk(8, 6), 32'h0000_9000, 2'd2, 2'd3);
    cyc("R10 old contents");
    lk(1'b1, mk(8, 6), "R10 visible next cycle");

    // One branch way, three non-branch ways
    do_reset(2'd1);
    wr(1'b1, mk(1, 9), 32'h0000_A000, 2'd1, 2'd1, "R8 branch part");
    wr(1'b1, mk(2, 9), 32'h0000_B000, 2'd2, 2'd2, "R8 branch part evict");
    lk(1'b1, mk(1, 9), "R8 single-way victim");
    for (int t = 3; t < 7; t++) wr(1'b0, mk(t, 9), 32'h0, 2'd0, 2'(t), "R8 non-branch part");
    lk(1'b1, mk(2, 9), "R8 other part untouched");
    lk(1'b0, mk(3, 9), "R8 non-branch victim");
    lk(1'b0, mk(6, 9), "R3 non-branch ways");
    lk(1'b1, mk(6, 9), "R4 outside partition");

    random_run(2'd0, 3000);
    random_run(2'd2, 3000);
    random_run(2'd3, 3000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule